// File: doc/BRIEF.md
# Single-pass identifier search sequencer

This block runs one pass of the binary tree walk that discovers the 64-bit identifiers of devices sharing a single open-drain data line. It does not time the line itself. It issues a series of slot requests to a separate bit-slot engine. The first request is a line reset that also senses presence. Next come the write slots of the search opcode. For each identifier position it then issues two read slots, for the bit and for its inverse, and one write slot that carries the chosen bit.

Software, or a higher controller, starts a pass with two inputs: the fork position returned by the previous pass and the identifier found by that pass. When the pass ends, the block gives the new identifier and the fork position to use next. Zero in that position means the last device has been found. To begin a fresh enumeration, start with the fork position set to 65 and any identifier. A one-cycle `done` pulse reports the end of a pass together with a 2-bit status.

Top module: `idscan_pass`

## Requirements
- R1: After `start` is taken in idle, the first slot request is a line reset (`slot_reset`=1).
- R2: If the reset slot is acknowledged with `slot_rbit`=0 (no device answered), the pass ends with `done` and `status`=2'b01, and no further slot is requested.
- R3: After a reset with presence, the block issues `CMD_BITS` write slots that carry the `SEARCH_OP` parameter least significant bit first. It issues these before any identifier slot.
- R4: Each identifier position uses exactly three slots in this order: read, read of the inverse, write. Both read slots drive `slot_wbit`=1.
- R5: If both reads at a position return 1, the pass ends at once with `done` and `status`=2'b10.
- R6: When the two reads differ, the bit from the first read is written back and stored.
- R7: When both reads return 0 at position p, the block picks 1 if `prev_disc` > p, or if the previous identifier bit at p is 1 and `prev_disc` != p. Otherwise it picks 0.
- R8: `next_disc` gives the last position, in processing order, at which R7 picked 1. If R7 never picked 1 it gives 0.
- R9: Positions are processed from 64 down to 1. Position p maps to bit 64-p of `new_id` (bit 0 first), and the written bit is the stored bit.
- R10: `done` is a single-cycle pulse. A successful pass reports `status`=2'b00. `busy` is high from the cycle after `start` until the cycle `done` rises. A `start` that arrives while busy is ignored.
- R11: A slot request, together with its reset flag and write bit, stays unchanged until `slot_ack` completes it. A request completes in any cycle where `slot_req` and `slot_ack` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a pass (taken only when idle) |
| prev_disc | input | POS_W | Fork position from the previous pass (65 for a first pass) |
| prev_id | input | ID_BITS | Identifier found by the previous pass |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| status | output | 2 | 00 ok, 01 no presence, 10 data error |
| new_id | output | ID_BITS | Identifier assembled during the pass |
| next_disc | output | POS_W | Fork position for the next pass, 0 when last |
| slot_req | output | 1 | Slot request to the bit-slot engine |
| slot_reset | output | 1 | Requested slot is a line reset |
| slot_wbit | output | 1 | Bit to drive in a data slot (1 for reads) |
| slot_ack | input | 1 | Slot complete |
| slot_rbit | input | 1 | Sampled line value, or presence for a reset |

## Verification
The bench builds the block with its default parameters: 64 identifier positions and the opcode 8'hF0. It attaches a wired-AND model of several devices with a varying acknowledge latency. With identifiers that differ only in bit 0 or only in bit 63, forks occur at the first and at the last position. This tests both ends of the position counter and the mapping from position to bit. A full enumeration chained through `next_disc` must return every device exactly once. The bench also covers an empty line, a forced 1,1 read pair and a `start` raised while a pass is running.

// File: rtl/idscan_pkg.sv
package idscan_pkg;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_NOPRES  = 2'd1,
    ST_DATAERR = 2'd2
  } scan_status_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RESET,
    PH_CMD,
    PH_RD_TRUE,
    PH_RD_CMPL,
    PH_WRITE
  } scan_phase_e;

  // Branch rule: agreeing devices dictate the bit; at a fork, go right (1)
  // while still above the old fork or where the old path already went right.
  function automatic logic pick_bit(input logic b, input logic cb,
                                    input logic disc_above, input logic disc_here,
                                    input logic prev_bit);
    if (b != cb) return b;
    return disc_above || (prev_bit && !disc_here);
  endfunction

  function automatic logic is_fork(input logic b, input logic cb);
    return !b && !cb;
  endfunction

endpackage

// File: rtl/idscan_choose.sv
module idscan_choose #(
  parameter int POS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             b,
  input  logic             cb,
  input  logic [POS_W-1:0] pos,
  input  logic [POS_W-1:0] prev_disc,
  input  logic             prev_bit,
  output logic             pick,
  output logic             mark,
  output logic             bad
);
  import idscan_pkg::*;

  logic disc_above, disc_here, fork_w;

  assign disc_above = prev_disc > pos;
  assign disc_here  = prev_disc == pos;
  assign fork_w     = is_fork(b, cb);
  assign pick       = pick_bit(b, cb, disc_above, disc_here, prev_bit);
  assign mark       = fork_w && pick;
  assign bad        = b && cb;

  AST_AGREE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    en && (b != cb) |-> pick == b);                                   // R6
  AST_FORK_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    en && !b && !cb && (prev_disc > pos) |-> pick);                   // R7
  AST_FORK_AT_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    en && !b && !cb && (prev_disc == pos) |-> !pick);                 // R7

endmodule

// File: rtl/idscan_idreg.sv
module idscan_idreg #(
  parameter int ID_BITS = 64,
  parameter int POS_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               wr_en,
  input  logic [POS_W-1:0]   pos,
  input  logic               bit_in,
  output logic [ID_BITS-1:0] id_q
);
  localparam int IDX_W = $clog2(ID_BITS);

  logic [POS_W-1:0] idx_full;
  logic [IDX_W-1:0] idx;

  assign idx_full = POS_W'(ID_BITS) - pos;
  assign idx      = idx_full[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)     id_q <= '0;
    else if (clr)   id_q <= '0;
    else if (wr_en) id_q[idx] <= bit_in;
  end

  AST_STORE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !clr |=> id_q[$past(idx)] == $past(bit_in));            // R9

endmodule

// File: rtl/idscan_pass.sv
module idscan_pass #(
  parameter int                  ID_BITS   = 64,
  parameter int                  CMD_BITS  = 8,
  parameter logic [CMD_BITS-1:0] SEARCH_OP = 8'hF0,
  parameter int                  POS_W     = $clog2(ID_BITS + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [POS_W-1:0]   prev_disc,
  input  logic [ID_BITS-1:0] prev_id,
  output logic               busy,
  output logic               done,
  output logic [1:0]         status,
  output logic [ID_BITS-1:0] new_id,
  output logic [POS_W-1:0]   next_disc,
  output logic               slot_req,
  output logic               slot_reset,
  output logic               slot_wbit,
  input  logic               slot_ack,
  input  logic               slot_rbit
);
  import idscan_pkg::*;

  localparam int CW    = (CMD_BITS > 1) ? $clog2(CMD_BITS) : 1;
  localparam int IDX_W = $clog2(ID_BITS);

  scan_phase_e        phase;
  scan_status_e       status_q;
  logic [CW-1:0]      cmd_cnt;
  logic [POS_W-1:0]   pos;
  logic [POS_W-1:0]   pdisc_q, ndisc_q;
  logic [ID_BITS-1:0] pid_q;
  logic               bit_t, pick_q, done_q;

  // named events
  logic xfer, take_start, cmp_xfer, wr_xfer, last_pos, last_cmd;
  logic pick_w, mark_w, bad_w, prev_bit;
  logic [POS_W-1:0] idx_full;

  assign xfer       = slot_req && slot_ack;
  assign take_start = (phase == PH_IDLE) && start;
  assign cmp_xfer   = (phase == PH_RD_CMPL) && xfer;
  assign wr_xfer    = (phase == PH_WRITE) && xfer;
  assign last_pos   = pos == POS_W'(1);
  assign last_cmd   = cmd_cnt == CW'(CMD_BITS - 1);
  assign idx_full   = POS_W'(ID_BITS) - pos;
  assign prev_bit   = pid_q[idx_full[IDX_W-1:0]];

  idscan_choose #(.POS_W(POS_W)) u_choose (
    .clk(clk), .rst_n(rst_n), .en(cmp_xfer),
    .b(bit_t), .cb(slot_rbit), .pos(pos), .prev_disc(pdisc_q),
    .prev_bit(prev_bit), .pick(pick_w), .mark(mark_w), .bad(bad_w)
  );

  idscan_idreg #(.ID_BITS(ID_BITS), .POS_W(POS_W)) u_idreg (
    .clk(clk), .rst_n(rst_n), .clr(take_start), .wr_en(wr_xfer),
    .pos(pos), .bit_in(pick_q), .id_q(new_id)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      status_q <= ST_OK;
      cmd_cnt  <= '0;
      pos      <= '0;
      pdisc_q  <= '0;
      ndisc_q  <= '0;
      pid_q    <= '0;
      bit_t    <= 1'b0;
      pick_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) begin
          pdisc_q <= prev_disc;
          pid_q   <= prev_id;
          ndisc_q <= '0;
          phase   <= PH_RESET;
        end
        PH_RESET: if (xfer) begin
          if (!slot_rbit) begin
            status_q <= ST_NOPRES;
            done_q   <= 1'b1;
            phase    <= PH_IDLE;
          end else begin
            cmd_cnt <= '0;
            phase   <= PH_CMD;
          end
        end
        PH_CMD: if (xfer) begin
          if (last_cmd) begin
            pos   <= POS_W'(ID_BITS);
            phase <= PH_RD_TRUE;
          end else begin
            cmd_cnt <= cmd_cnt + 1'b1;
          end
        end
        PH_RD_TRUE: if (xfer) begin
          bit_t <= slot_rbit;
          phase <= PH_RD_CMPL;
        end
        PH_RD_CMPL: if (xfer) begin
          if (bad_w) begin
            status_q <= ST_DATAERR;
            done_q   <= 1'b1;
            phase    <= PH_IDLE;
          end else begin
            pick_q <= pick_w;
            if (mark_w) ndisc_q <= pos;
            phase <= PH_WRITE;
          end
        end
        PH_WRITE: if (xfer) begin
          if (last_pos) begin
            status_q <= ST_OK;
            done_q   <= 1'b1;
            phase    <= PH_IDLE;
          end else begin
            pos   <= pos - 1'b1;
            phase <= PH_RD_TRUE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (phase)
      PH_CMD:   slot_wbit = SEARCH_OP[cmd_cnt];
      PH_WRITE: slot_wbit = pick_q;
      default:  slot_wbit = 1'b1;
    endcase
  end

  assign slot_req   = phase != PH_IDLE;
  assign slot_reset = phase == PH_RESET;
  assign busy       = phase != PH_IDLE;
  assign done       = done_q;
  assign status     = status_q;
  assign next_disc  = ndisc_q;

  AST_START_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> slot_req && slot_reset);                       // R1
  AST_NO_PRESENCE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req && slot_ack && slot_reset && !slot_rbit |=> done && status == 2'b01 && !slot_req); // R2
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RD_TRUE || phase == PH_RD_CMPL) |-> slot_wbit);     // R4
  AST_BOTH_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_xfer && bit_t && slot_rbit |=> done && status == 2'b10);      // R5
  AST_DISC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    next_disc <= POS_W'(ID_BITS));                                    // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                  // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req && !slot_ack |=> slot_req && $stable(slot_reset) && $stable(slot_wbit)); // R11

endmodule

// File: tb/idscan_pass_bench.sv
`timescale 1ns/1ps
module idscan_pass_bench;
  localparam int          NB  = 64;
  localparam int          PW  = 7;
  localparam logic [7:0]  OPC = 8'hF0;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [PW-1:0] prev_disc = '0;
  logic [NB-1:0] prev_id = '0;
  logic busy, done, slot_req, slot_reset, slot_wbit;
  logic [1:0] status;
  logic [NB-1:0] new_id;
  logic [PW-1:0] next_disc;
  logic slot_ack = 1'b0, slot_rbit = 1'b0;

  always #2 clk = ~clk;

  idscan_pass u_idscan_pass (
    .clk(clk), .rst_n(rst_n), .start(start), .prev_disc(prev_disc),
    .prev_id(prev_id), .busy(busy), .done(done), .status(status),
    .new_id(new_id), .next_disc(next_disc), .slot_req(slot_req),
    .slot_reset(slot_reset), .slot_wbit(slot_wbit), .slot_ack(slot_ack),
    .slot_rbit(slot_rbit)
  );

  int checks = 0, fails = 0;
  logic [NB-1:0] dev_id[8];
  bit dev_on[8];
  int ndev = 0;
  bit inject = 0;
  int inj_i = 0;
  int slot_k = 0;
  bit expect_reset = 0;
  logic [NB-1:0] written;

  task automatic chk(input bit ok, input string tag, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // wired-AND line value for the current read
  function automatic logic line_and(input int i, input bit inv);
    logic v = 1'b1;
    for (int d = 0; d < ndev; d++)
      if (dev_on[d]) v &= inv ? ~dev_id[d][i] : dev_id[d][i];
    return v;
  endfunction

  task automatic serve();
    if (expect_reset) begin
      chk(slot_reset, "R1", {63'd0, slot_reset}, 64'd1);
      expect_reset = 0;
    end
    if (slot_reset) begin
      for (int d = 0; d < 8; d++) dev_on[d] = 1;
      slot_k = 0;
      slot_rbit = ndev > 0;
    end else begin
      if (slot_k < 8) begin
        chk(slot_wbit == OPC[slot_k], "R3", {63'd0, slot_wbit}, {63'd0, OPC[slot_k]});
        slot_rbit = 1'b1;
      end else begin
        int j = slot_k - 8;
        int i = j / 3;
        int s = j % 3;
        if (s < 2) begin
          chk(slot_wbit == 1'b1, "R4", {63'd0, slot_wbit}, 64'd1);
          slot_rbit = (inject && i == inj_i) ? 1'b1 : line_and(i, s == 1);
        end else begin
          written[i] = slot_wbit;
          for (int d = 0; d < ndev; d++)
            if (dev_id[d][i] != slot_wbit) dev_on[d] = 0;
          slot_rbit = 1'b1;
        end
      end
      slot_k++;
    end
  endtask

  // bit-slot responder with varying latency
  initial begin
    bit fresh = 1;
    bit sr, sw;
    int wait_cnt = 0, lat = 0;
    forever begin
      @(negedge clk);
      if (slot_ack) begin
        slot_ack = 1'b0;
        fresh = 1;
      end else if (slot_req) begin
        if (fresh) begin
          fresh = 0; sr = slot_reset; sw = slot_wbit;
          lat++; wait_cnt = lat % 3;
        end
        if (wait_cnt > 0) wait_cnt--;
        else begin
          chk(slot_reset == sr && slot_wbit == sw, "R11", {62'd0, slot_reset, slot_wbit}, {62'd0, sr, sw});
          serve();
          slot_ack = 1'b1;
        end
      end
    end
  end

  // behavioural reference of one pass
  task automatic ref_search(input int pd, input logic [NB-1:0] pid,
                            output logic [NB-1:0] rid, output int nd, output int st);
    bit on[8];
    rid = '0; nd = 0;
    if (ndev == 0) begin st = 1; return; end
    for (int d = 0; d < 8; d++) on[d] = 1;
    for (int i = 0; i < NB; i++) begin
      int p = NB - i;
      bit seen0 = 0, seen1 = 0, take;
      for (int d = 0; d < ndev; d++)
        if (on[d]) begin
          if (dev_id[d][i]) seen1 = 1; else seen0 = 1;
        end
      if ((inject && i == inj_i) || (!seen0 && !seen1)) begin st = 2; return; end
      if (seen0 && seen1) begin
        take = (pd > p) || (pid[i] && pd != p);
        if (take) nd = p;
      end else take = seen1;
      rid[i] = take;
      for (int d = 0; d < ndev; d++) if (dev_id[d][i] != take) on[d] = 0;
    end
    st = 0;
  endtask

  task automatic run_pass(input int pd, input logic [NB-1:0] pid, input bit poke,
                          output logic [NB-1:0] id, output int nd, output int st);
    int n = 0;
    @(negedge clk);
    prev_disc = PW'(pd); prev_id = pid; start = 1'b1; expect_reset = 1;
    written = '0;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R10", {63'd0, busy}, 64'd1);
    while (!done) begin
      @(negedge clk);
      n++;
      if (poke && n == 100) begin
        prev_disc = PW'(1); prev_id = ~pid; start = 1'b1;
      end else start = 1'b0;
    end
    start = 1'b0;
    id = new_id; nd = int'(next_disc); st = int'(status);
    chk(!busy, "R10", {63'd0, busy}, 64'd0);
    @(negedge clk);
    chk(!done, "R10", {63'd0, done}, 64'd0);
  endtask

  task automatic pass_and_compare(input int pd, input logic [NB-1:0] pid, input bit poke,
                                  output logic [NB-1:0] id, output int nd, output int st);
    logic [NB-1:0] rid; int rnd, rst;
    ref_search(pd, pid, rid, rnd, rst);
    run_pass(pd, pid, poke, id, nd, st);
    chk(st == rst, "R5/R10 status", 64'(st), 64'(rst));
    if (rst == 0) begin
      chk(id == rid, "R6 R7 R9 id", id, rid);
      chk(nd == rnd, "R8 next_disc", 64'(nd), 64'(rnd));
      chk(written == id, "R9 written vs stored", id, written);
    end
  endtask

  task automatic set_devs(input int n);
    ndev = n;
  endtask

  initial begin
    logic [NB-1:0] id, pid;
    int nd, st, pd, found;
    bit hit[8];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !slot_req, "R10 reset", {61'd0, busy, done, slot_req}, 64'd0);
    chk(next_disc == 0, "R8 reset", 64'(next_disc), 64'd0);

    // enumeration of four devices, forks at positions 64 and 1
    dev_id[0] = 64'h0000_0000_0000_0000;
    dev_id[1] = 64'h0000_0000_0000_0001;
    dev_id[2] = 64'h8000_0000_0000_0000;
    dev_id[3] = 64'h5A5A_1234_F00D_C3C3;
    set_devs(4);
    for (int d = 0; d < 8; d++) hit[d] = 0;
    pd = 65; pid = '0; found = 0;
    for (int k = 0; k < 6; k++) begin
      pass_and_compare(pd, pid, 0, id, nd, st);
      for (int d = 0; d < ndev; d++)
        if (id == dev_id[d]) begin
          chk(!hit[d], "R8 distinct", id, dev_id[d]);
          hit[d] = 1; found++;
        end
      pd = nd; pid = id;
      if (nd == 0) break;
    end
    chk(found == 4, "R8 enumerate all", 64'(found), 64'd4);

    // single device: no fork, last-device marker
    dev_id[0] = 64'hDEAD_BEEF_0123_4567;
    set_devs(1);
    pass_and_compare(65, '0, 0, id, nd, st);
    chk(id == dev_id[0], "R6 single", id, dev_id[0]);
    chk(nd == 0, "R8 single", 64'(nd), 64'd0);

    // start while busy is ignored
    dev_id[1] = 64'hDEAD_BEEF_0123_4566;
    set_devs(2);
    pass_and_compare(65, '0, 1, id, nd, st);
    chk(nd == 64, "R10 poke ignored", 64'(nd), 64'd64);

    // revisit at the old fork position takes 0
    pass_and_compare(64, 64'hDEAD_BEEF_0123_4567, 0, id, nd, st);
    chk(id == dev_id[1] && nd == 0, "R7 old fork", id, dev_id[1]);

    // forced 1,1 read pair
    inject = 1; inj_i = 5;
    pass_and_compare(65, '0, 0, id, nd, st);
    chk(st == 2, "R5", 64'(st), 64'd2);
    inject = 0;

    // empty line
    set_devs(0);
    pass_and_compare(65, '0, 0, id, nd, st);
    chk(st == 1, "R2", 64'(st), 64'd1);
    repeat (10) @(negedge clk);
    chk(!slot_req, "R2 no further slot", {63'd0, slot_req}, 64'd0);

    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

endmodule